// File: doc/BRIEF.md
# Predicated Tile-Slice Load Sequencer

This block fills one slice of a small on-chip matrix tile store from memory. A command names a tile, a slice position, a row-or-column direction, a base address, a scalar element offset counted in doublewords, and a byte-granular predicate mask. The sequencer walks the elements of the slice in ascending order. For each active element it issues one 64-bit read on a valid/ready request port and waits for the response before going on. Inactive elements are filled with zeros and cause no memory traffic. After the last element, the assembled slice is written into the tile store in a single update, and a one-cycle completion pulse is raised.

When the base comes from the stack pointer and at least one element is active, the base must be 16-byte aligned. If it is not, the command ends at once with a fault pulse beside the completion pulse. No read is issued and the tile store is not changed. A combinational read-back port lets surrounding logic, or a bench, inspect any element of any tile.

Top module: `tile_slice_loader`

## Requirements
- R1: The written slice number is (cmdIndex + cmdOffs) mod DIM, where DIM = VL/64 (4 by default), cmdIndex is 32-bit unsigned, and cmdOffs is a single bit (0 or 1).
- R2: Element e is read from address cmdBase + (cmdElemOffs + e) × 8, computed modulo 2^64. Active elements are read in ascending e, one read each.
- R3: Element e is active when cmdPred bit e×8 is 1; other predicate bits are ignored. An inactive element issues no read and is stored as zero.
- R4: With cmdVert = 0, element e lands at row = slice, column = e of tile cmdTile (0–7). With cmdVert = 1, it lands at row = e, column = slice. No other tile element changes.
- R5: If cmdBaseIsSp = 1, at least one element is active, and cmdBase[3:0] ≠ 0, then fault pulses together with done. No read is issued and the tile store is unchanged.
- R6: No fault is raised when cmdBaseIsSp = 0 (even for an unaligned base), or when no element is active (even for a misaligned stack-pointer base). In both cases the slice is written normally.
- R7: At most one read is outstanding. A request holds its address until accepted, and no new request appears until the response has arrived.
- R8: cmdReady is high only while idle, and commands are taken when cmdValid and cmdReady are both high. done is a one-cycle pulse ending each command, and the new slice is visible on the read-back port from the following cycle.
- R9: Synchronous reset clears every tile element to zero and drives done, fault and memReqValid low, with cmdReady high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Sequencer idle, command accepted |
| cmdTile | input | 3 | Target tile number |
| cmdIndex | input | 32 | Slice index value |
| cmdOffs | input | 1 | Immediate slice offset (0 or 1) |
| cmdVert | input | 1 | 1 = column slice, 0 = row slice |
| cmdBase | input | 64 | Base byte address |
| cmdElemOffs | input | 64 | Scalar offset in doublewords (0 when absent) |
| cmdPred | input | 32 | Predicate, one bit per byte of the vector |
| cmdBaseIsSp | input | 1 | Base taken from the stack pointer |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 64 | Read byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data |
| done | output | 1 | Command completion pulse |
| fault | output | 1 | Alignment fault pulse, with done |
| rdTile | input | 3 | Read-back tile select |
| rdRow | input | 2 | Read-back row select |
| rdCol | input | 2 | Read-back column select |
| rdData | output | 64 | Read-back element |

## Verification
The hardest case to reach is a stack-pointer base that is misaligned but whose only set predicate bits lie off the governing positions e×8, so no element is active. The alignment check must then stay silent while the slice is still written as zeros. Random commands rarely hit this, so directed commands build such masks explicitly, along with the offset-wrap case where index 0xFFFFFFFF plus one folds to slice 0. Random commands then mix sparse masks, directions and tiles, while the memory model varies request acceptance and response latency to stress the one-outstanding rule.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RUN, S_WAIT, S_COMMIT, S_FAULT
  } tslState_t;

  typedef struct packed {
    logic loadCmd;
    logic captureData;
    logic zeroElem;
    logic commit;
  } tslStrobe_t;
endpackage

// File: rtl/tsl_ctrl.sv
module tsl_ctrl
  import tsl_pkg::*;
#(
  parameter int DIM = 4,
  parameter int EW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdValid,
  input  logic          elemActive,
  input  logic          misaligned,
  input  logic          memReqReady,
  input  logic          memRspValid,
  output tslStrobe_t    strobe,
  output logic [EW-1:0] elemIdx,
  output logic          memReqValid,
  output logic          cmdReady,
  output logic          done,
  output logic          fault
);
  localparam logic [EW-1:0] LAST = EW'(DIM - 1);

  tslState_t state, stateNext;
  logic [EW-1:0] elemNext;

  always_comb begin
    stateNext = state;
    elemNext  = elemIdx;
    strobe    = '0;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        strobe.loadCmd = 1'b1;
        elemNext       = '0;
        stateNext      = S_CHECK;
      end
      S_CHECK: stateNext = misaligned ? S_FAULT : S_RUN;
      S_RUN: begin
        if (elemActive) begin
          if (memReqReady) stateNext = S_WAIT;
        end else begin
          strobe.zeroElem = 1'b1;
          if (elemIdx == LAST) stateNext = S_COMMIT;
          else elemNext = elemIdx + 1'b1;
        end
      end
      S_WAIT: if (memRspValid) begin
        strobe.captureData = 1'b1;
        if (elemIdx == LAST) stateNext = S_COMMIT;
        else begin
          elemNext  = elemIdx + 1'b1;
          stateNext = S_RUN;
        end
      end
      S_COMMIT: begin
        strobe.commit = 1'b1;
        stateNext     = S_IDLE;
      end
      S_FAULT: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      elemIdx <= '0;
    end else begin
      state   <= stateNext;
      elemIdx <= elemNext;
    end
  end

  assign memReqValid = (state == S_RUN) && elemActive;
  assign cmdReady    = (state == S_IDLE);
  assign done        = (state == S_COMMIT) || (state == S_FAULT);
  assign fault       = (state == S_FAULT);
endmodule

// File: rtl/tsl_datapath.sv
module tsl_datapath
  import tsl_pkg::*;
#(
  parameter int VL        = 256,
  parameter int ADDR_W    = 64,
  parameter int NUM_TILES = 8,
  parameter int DIM       = VL / 64,
  parameter int EW        = 2,
  parameter int TW        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  tslStrobe_t        strobe,
  input  logic [EW-1:0]     elemIdx,
  input  logic [TW-1:0]     cmdTile,
  input  logic [31:0]       cmdIndex,
  input  logic              cmdOffs,
  input  logic              cmdVert,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [ADDR_W-1:0] cmdElemOffs,
  input  logic [VL/8-1:0]   cmdPred,
  input  logic              cmdBaseIsSp,
  input  logic [63:0]       memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              elemActive,
  output logic              misaligned,
  input  logic [TW-1:0]     rdTile,
  input  logic [EW-1:0]     rdRow,
  input  logic [EW-1:0]     rdCol,
  output logic [63:0]       rdData
);
  localparam int PL = VL / 8;

  logic [TW-1:0]     tileR;
  logic [EW-1:0]     sliceR;
  logic              vertR, spR;
  logic [ADDR_W-1:0] baseR, offR;
  logic [PL-1:0]     predR;
  logic [63:0]       sliceBuf [DIM];
  logic [63:0]       tiles [NUM_TILES][DIM][DIM];
  logic [DIM-1:0]    activeVec;
  logic [32:0]       sliceSum;

  assign sliceSum = {1'b0, cmdIndex} + 33'(cmdOffs);

  for (genvar e = 0; e < DIM; e++) begin : g_act
    assign activeVec[e] = predR[e*8];
  end

  assign elemActive = activeVec[elemIdx];
  assign misaligned = spR && (|activeVec) && (baseR[3:0] != 4'd0);
  assign memReqAddr = baseR + ((offR + ADDR_W'(elemIdx)) << 3);
  assign rdData     = tiles[rdTile][rdRow][rdCol];

  always_ff @(posedge clk) begin
    if (rst) begin
      tileR  <= '0;
      sliceR <= '0;
      vertR  <= 1'b0;
      spR    <= 1'b0;
      baseR  <= '0;
      offR   <= '0;
      predR  <= '0;
      for (int e = 0; e < DIM; e++) sliceBuf[e] <= '0;
      for (int t = 0; t < NUM_TILES; t++)
        for (int r = 0; r < DIM; r++)
          for (int c = 0; c < DIM; c++) tiles[t][r][c] <= '0;
    end else begin
      if (strobe.loadCmd) begin
        tileR  <= cmdTile;
        sliceR <= EW'(sliceSum % 33'(DIM));
        vertR  <= cmdVert;
        spR    <= cmdBaseIsSp;
        baseR  <= cmdBase;
        offR   <= cmdElemOffs;
        predR  <= cmdPred;
      end
      if (strobe.captureData) sliceBuf[elemIdx] <= memRspData;
      if (strobe.zeroElem)    sliceBuf[elemIdx] <= '0;
      if (strobe.commit) begin
        for (int e = 0; e < DIM; e++) begin
          if (vertR) tiles[tileR][EW'(e)][sliceR] <= sliceBuf[e];
          else       tiles[tileR][sliceR][EW'(e)] <= sliceBuf[e];
        end
      end
    end
  end
endmodule

// File: rtl/tile_slice_loader.sv
module tile_slice_loader
  import tsl_pkg::*;
#(
  parameter int VL        = 256,
  parameter int ADDR_W    = 64,
  parameter int NUM_TILES = 8,
  localparam int DIM      = VL / 64,
  localparam int EW       = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int TW       = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1,
  localparam int PL       = VL / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [TW-1:0]     cmdTile,
  input  logic [31:0]       cmdIndex,
  input  logic              cmdOffs,
  input  logic              cmdVert,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [ADDR_W-1:0] cmdElemOffs,
  input  logic [PL-1:0]     cmdPred,
  input  logic              cmdBaseIsSp,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [63:0]       memRspData,
  output logic              done,
  output logic              fault,
  input  logic [TW-1:0]     rdTile,
  input  logic [EW-1:0]     rdRow,
  input  logic [EW-1:0]     rdCol,
  output logic [63:0]       rdData
);
  tslStrobe_t    strobe;
  logic [EW-1:0] elemIdx;
  logic          elemActive, misaligned;

  tsl_ctrl #(.DIM(DIM), .EW(EW)) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .elemActive(elemActive),
    .misaligned(misaligned), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .strobe(strobe), .elemIdx(elemIdx), .memReqValid(memReqValid),
    .cmdReady(cmdReady), .done(done), .fault(fault)
  );

  tsl_datapath #(.VL(VL), .ADDR_W(ADDR_W), .NUM_TILES(NUM_TILES),
                 .DIM(DIM), .EW(EW), .TW(TW)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .elemIdx(elemIdx),
    .cmdTile(cmdTile), .cmdIndex(cmdIndex), .cmdOffs(cmdOffs), .cmdVert(cmdVert),
    .cmdBase(cmdBase), .cmdElemOffs(cmdElemOffs), .cmdPred(cmdPred),
    .cmdBaseIsSp(cmdBaseIsSp), .memRspData(memRspData), .memReqAddr(memReqAddr),
    .elemActive(elemActive), .misaligned(misaligned),
    .rdTile(rdTile), .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData)
  );
endmodule

// File: rtl/tsl_checker.sv
module tsl_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cmdReady,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              done,
  input logic              fault
);
  // R7: an unaccepted request stays up with the same address
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R7: after acceptance no further request until the response
  p_single_outstanding_r7: assert property (@(posedge clk) disable iff (rst)
    memReqValid && memReqReady |=> !memReqValid);

  // R5: fault only appears together with done
  p_fault_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: an idle sequencer neither reads nor completes
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    cmdReady |-> !memReqValid && !done);
endmodule

bind tile_slice_loader tsl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cmdReady(cmdReady), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr), .done(done), .fault(fault)
);

// File: tb/sim_tile_slice_loader.sv
module sim_tile_slice_loader;
  localparam int DIM = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmdValid = 1'b0, cmdReady;
  logic [2:0]  cmdTile = '0;
  logic [31:0] cmdIndex = '0;
  logic        cmdOffs = 1'b0, cmdVert = 1'b0, cmdBaseIsSp = 1'b0;
  logic [63:0] cmdBase = '0, cmdElemOffs = '0;
  logic [31:0] cmdPred = '0;
  logic        memReqValid, memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        done, fault;
  logic [2:0]  rdTile = '0;
  logic [1:0]  rdRow = '0, rdCol = '0;
  logic [63:0] rdData;

  int total = 0, bad = 0;
  logic [63:0] mdl [8][DIM][DIM];
  logic [63:0] reqLog [16];
  int reqCount = 0;

  always #5 clk = ~clk;

  tile_slice_loader u0 (.*);

  function automatic logic [63:0] memData(logic [63:0] a);
    return {a[31:0], ~a[31:0]} ^ 64'h0F1E_2D3C_4B5A_6978;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: random acceptance and latency
  initial begin
    bit pend = 0;
    int cnt = 0;
    logic [63:0] pAddr = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memReqReady = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = memData(pAddr);
          pend = 0;
        end else cnt--;
      end else if (memReqValid && ($urandom % 2 == 0)) begin
        memReqReady = 1'b1;
        pend  = 1;
        pAddr = memReqAddr;
        cnt   = $urandom % 3;
        if (reqCount < 16) reqLog[reqCount] = memReqAddr;
        reqCount++;
      end
    end
  end

  task automatic compareTiles(input string tag);
    int mism = 0;
    logic [63:0] fa = '0, fe = '0;
    for (int t = 0; t < 8; t++)
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++) begin
          rdTile = 3'(t); rdRow = 2'(r); rdCol = 2'(c);
          #1;
          if (rdData !== mdl[t][r][c]) begin
            if (mism == 0) begin fa = rdData; fe = mdl[t][r][c]; end
            mism++;
          end
        end
    chk(mism == 0, tag, fa, fe);
  endtask

  task automatic runCmd(input logic [2:0] t, input logic [31:0] idx, input logic offs,
                        input logic vert, input logic [63:0] base, input logic [63:0] eoff,
                        input logic [31:0] pred, input logic sp);
    bit act [DIM];
    bit anyAct = 0, expFault;
    int expReq = 0, slice, wait_n = 0;
    logic [63:0] expAddr [DIM];
    for (int e = 0; e < DIM; e++) begin
      act[e] = pred[e*8];
      if (act[e]) begin
        anyAct = 1;
        expAddr[expReq] = base + ((eoff + 64'(e)) << 3);
        expReq++;
      end
    end
    expFault = sp && anyAct && (base[3:0] != 4'd0);
    slice = int'((64'(idx) + 64'(offs)) % 64'(DIM));
    reqCount = 0;
    @(negedge clk);
    cmdTile = t; cmdIndex = idx; cmdOffs = offs; cmdVert = vert;
    cmdBase = base; cmdElemOffs = eoff; cmdPred = pred; cmdBaseIsSp = sp;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(cmdReady == 1'b0, "R8 busy after accept", 64'(cmdReady), 64'd0);
    while (!done && wait_n < 200) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done == 1'b1, "R8 done reached", 64'(done), 64'd1);
    chk(fault == expFault, expFault ? "R5 fault raised" : "R6 no fault", 64'(fault), 64'(expFault));
    chk(reqCount == (expFault ? 0 : expReq), "R3 read count", 64'(reqCount), 64'(expFault ? 0 : expReq));
    if (!expFault)
      for (int i = 0; i < expReq && i < reqCount; i++)
        chk(reqLog[i] == expAddr[i], "R2 read address", reqLog[i], expAddr[i]);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", 64'(done), 64'd0);
    if (!expFault)
      for (int e = 0; e < DIM; e++) begin
        logic [63:0] v = act[e] ? memData(base + ((eoff + 64'(e)) << 3)) : 64'd0;
        if (vert) mdl[t][e][slice] = v;
        else      mdl[t][slice][e] = v;
      end
    compareTiles(expFault ? "R5 tile unchanged" : "R1 R4 slice contents");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int t = 0; t < 8; t++)
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++) mdl[t][r][c] = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk(cmdReady == 1'b1 && done == 1'b0 && fault == 1'b0 && memReqValid == 1'b0,
        "R9 reset outputs", {cmdReady, done, fault, memReqValid}, 64'h8);
    compareTiles("R9 tiles cleared");

    // R1 R4: row slice, all active
    runCmd(3'd0, 32'd0, 1'b0, 1'b0, 64'h1000, 64'd0, 32'hFFFF_FFFF, 1'b0);
    // R1 offset wraps: index 3 + 1 -> slice 0, column
    runCmd(3'd7, 32'd3, 1'b1, 1'b1, 64'h2000, 64'd5, 32'h0101_0101, 1'b0);
    // R1 index 0xFFFFFFFF + 1 folds to slice 0
    runCmd(3'd3, 32'hFFFF_FFFF, 1'b1, 1'b0, 64'h3000, 64'd2, 32'h0000_0101, 1'b0);
    // R3: nothing active -> zeros, no reads
    runCmd(3'd0, 32'd0, 1'b0, 1'b0, 64'h1000, 64'd0, 32'h0000_0000, 1'b0);
    // R3: only non-governing bits set
    runCmd(3'd1, 32'd2, 1'b0, 1'b1, 64'h4000, 64'd0, 32'hFEFE_FEFE, 1'b0);
    // R5: misaligned stack-pointer base with active elements
    runCmd(3'd7, 32'd3, 1'b1, 1'b1, 64'h5008, 64'd0, 32'h0000_0001, 1'b1);
    // R6: misaligned stack-pointer base, no active elements
    runCmd(3'd2, 32'd1, 1'b0, 1'b0, 64'h5004, 64'd0, 32'h0202_0202, 1'b1);
    // R6: unaligned ordinary base, address wrap near top
    runCmd(3'd4, 32'd1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF3, 64'd1, 32'h0101_0001, 1'b0);
    // aligned stack-pointer base reads normally
    runCmd(3'd5, 32'd6, 1'b0, 1'b0, 64'h6010, 64'd3, 32'h0100_0100, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] p = $urandom;
      logic [63:0] b = {$urandom, $urandom};
      if ($urandom % 2 == 0) b[3:0] = 4'd0;
      runCmd(3'($urandom), $urandom, 1'($urandom), 1'($urandom), b,
             64'($urandom % 64), p, 1'($urandom % 4 == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule